// File: doc/BRIEF.md
# Sequential Image Readout Prefetcher

This block lets a narrow 8-bit processor bus read a stored image one pixel word after another from a shared SRAM. It does not own the SRAM. An external scheduler grants access slots, and the block keeps a small queue of words already fetched. When the processor comes to read, the next pixel is already waiting and no SRAM latency appears on the bus.

The block holds a fetch pointer. It asks the scheduler for the word at that pointer whenever the queue has room. Each returned 15-bit word is queued when the scheduler pulses its data-ready strobe. The oldest queued word is visible through two byte registers, one for the low part and one for the high part. The word leaves the queue only when a read of the high-byte register finishes, which is when chip-select goes back high, so the bus value cannot change partway through a cycle.

A write to the restart register sends the pointer back to the start of the image and empties the queue.

Top module: `img_fetch_engine`

## Requirements
- R1: While reset is held, `fetch_req` is low and `fetch_addr` is zero. Whenever the queue is empty, a read of register 0 or register 1 returns 0x00.
- R2: `fetch_req` is raised one cycle after the queue holds fewer than DEPTH words and no request is pending. It never stays high while the queue holds DEPTH words.
- R3: Only one request is ever pending. Once raised, `fetch_req` stays high and `fetch_addr` stays unchanged until a `fetch_strb` arrives, unless a restart occurs.
- R4: A `fetch_strb` that answers a pending request queues `fetch_data` and moves `fetch_addr` up by one. The address wraps from 2^ADDR_W-1 to 0.
- R5: Register 0 (`cpu_addr`=2'b00) returns bits 7:0 of the oldest queued word. Register 1 (`cpu_addr`=2'b01) returns bit 7 as zero and bits 6:0 as bits 14:8 of that word. Register 3 returns 0x00.
- R6: The oldest word is removed only on the rising edge of `cpu_cs_n` that ends a read of register 1. Reads of register 0 never remove a word, and the read data stays stable while `cpu_cs_n` is low.
- R7: A write (`cpu_we`=1) to register 2 (`cpu_addr`=2'b10) takes effect on the rising edge of `cpu_cs_n`. It sets `fetch_addr` to zero, empties the queue and drops any pending request. The strobe that answers the dropped request is discarded. Writes to registers 0 and 1 have no effect.
- R8: Words are read out in the order they were fetched, so the k-th pixel read after a restart is the word at address k mod 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_cs_n | input | 1 | Processor chip-select, active low |
| cpu_we | input | 1 | Cycle is a write when high |
| cpu_addr | input | 2 | Register select |
| cpu_rdata | output | 8 | Read data byte |
| fetch_req | output | 1 | Request to the SRAM scheduler |
| fetch_addr | output | ADDR_W (18) | Address of the word to fetch |
| fetch_strb | input | 1 | One-cycle data-ready strobe from the scheduler |
| fetch_data | input | 15 | Returned pixel word |

## Verification
The scheduler model answers each request after a random delay of 0 to 5 cycles, and the processor reads at random spacing. The returned words are an address hash that sets bit 14 for some addresses and clears it for others, so a wrong byte split or a lost or repeated word shows up as a value mismatch.

Directed cases cover the following:
- repeated low-byte reads and a stretched high-byte read, which separate popping at the end of the cycle from popping at any other time;
- a long idle period, which shows that requests stop when the queue is full;
- restarts issued while a fetch is in flight, which test whether the late strobe is discarded;
- a narrowed address width, which reaches the pointer wrap.

// File: rtl/img_fetch_engine.sv
module img_fetch_engine #(
  parameter int ADDR_W = 18,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_cs_n,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_addr,
  output logic [7:0]        cpu_rdata,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_strb,
  input  logic [14:0]       fetch_data
);
  localparam int PIX_W = 15;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] REG_LO = 2'd0, REG_HI = 2'd1, REG_RESTART = 2'd2;

  logic [PIX_W-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic cs_q, cyc_we, discard;
  logic [1:0] cyc_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
      cyc_we <= 1'b0;
      cyc_addr <= '0;
    end else begin
      cs_q <= cpu_cs_n;
      if (!cpu_cs_n) begin
        cyc_we <= cpu_we;
        cyc_addr <= cpu_addr;
      end
    end
  end

  wire cyc_end = !cs_q && cpu_cs_n;
  wire restart = cyc_end && cyc_we && (cyc_addr == REG_RESTART);
  wire pop     = cyc_end && !cyc_we && (cyc_addr == REG_HI) && (cnt != '0);
  wire push    = fetch_strb && fetch_req && !restart;

  always_ff @(posedge clk)
    if (push) mem[wptr] <= fetch_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_req <= 1'b0;
      fetch_addr <= '0;
      wptr <= '0;
      rptr <= '0;
      cnt <= '0;
      discard <= 1'b0;
    end else if (restart) begin
      fetch_addr <= '0;
      wptr <= '0;
      rptr <= '0;
      cnt <= '0;
      fetch_req <= 1'b0;
      discard <= (fetch_req || discard) && !fetch_strb;
    end else begin
      if (push) begin
        wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        fetch_addr <= fetch_addr + 1'b1;
      end
      if (pop) rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push && !pop) cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
      if (fetch_strb && discard) discard <= 1'b0;
      if (push) fetch_req <= 1'b0;
      else if (!fetch_req && !discard && cnt < CW'(DEPTH)) fetch_req <= 1'b1;
    end
  end

  wire [PIX_W-1:0] head = (cnt != '0) ? mem[rptr] : '0;
  assign cpu_rdata = (cpu_addr == REG_LO) ? head[7:0] :
                     (cpu_addr == REG_HI) ? {1'b0, head[14:8]} : 8'h00;
endmodule

module img_fetch_engine_chk #(
  parameter int ADDR_W = 18,
  parameter int DEPTH  = 4,
  parameter int CW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              strb,
  input logic              restart,
  input logic [ADDR_W-1:0] addr,
  input logic [CW-1:0]     cnt,
  input logic              cs_n,
  input logic [1:0]        cpu_addr,
  input logic [7:0]        rdata
);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
  // R2
  full_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt == CW'(DEPTH) |-> !req);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !strb && !restart |=> req && $stable(addr));
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && strb && !restart |=> addr == ADDR_W'($past(addr) + 1'b1));
  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> addr == '0 && cnt == '0 && !req);
  // R5
  hi_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr == 2'd1 |-> !rdata[7]);
  // R6
  read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n && !$past(cs_n) && cpu_addr == 2'd1 && $past(cpu_addr) == 2'd1 && cnt != '0 && $past(cnt) != '0
    |-> $stable(rdata));
endmodule

bind img_fetch_engine img_fetch_engine_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(fetch_req), .strb(fetch_strb), .restart(restart),
  .addr(fetch_addr), .cnt(cnt), .cs_n(cpu_cs_n), .cpu_addr(cpu_addr), .rdata(cpu_rdata)
);

// File: tb/img_fetch_engine_test.sv
module img_fetch_engine_test;
  localparam int AW = 6;
  localparam int DEP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] rdata;
  logic req, strb = 1'b0;
  logic [AW-1:0] faddr;
  logic [14:0] fdata = '0;

  int errors = 0, checks = 0, exp_idx = 0;

  always #4 clk = ~clk;

  img_fetch_engine #(.ADDR_W(AW), .DEPTH(DEP)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_cs_n(cs_n), .cpu_we(we), .cpu_addr(addr),
    .cpu_rdata(rdata), .fetch_req(req), .fetch_addr(faddr),
    .fetch_strb(strb), .fetch_data(fdata));

  function automatic logic [14:0] pix(int a);
    int m = a % (1 << AW);
    return 15'((m * 1237 + 17185) ^ (m << 9));
  endfunction

  // scheduler model: variable latency responder
  logic inflight = 1'b0;
  int wait_c = 0;
  logic [AW-1:0] lat_addr = '0;
  always @(negedge clk) begin
    strb <= 1'b0;
    if (inflight) begin
      if (wait_c == 0) begin
        strb <= 1'b1;
        fdata <= pix(int'(lat_addr));
        inflight <= 1'b0;
      end else wait_c <= wait_c - 1;
    end else if (req && rst_n) begin
      lat_addr <= faddr;
      wait_c <= int'($urandom % 6);
      inflight <= 1'b1;
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_byte(input logic [1:0] a, input int hold, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R6 stable during read", rdata, d);
    end
    cs_n = 1'b1;
  endtask

  task automatic read_pixel(input int hold, output logic [14:0] p);
    logic [7:0] lo, hi;
    read_byte(2'd0, 0, lo);
    read_byte(2'd1, hold, hi);
    chk("R5 high byte top bit", hi[7], 1'b0);
    p = {hi[6:0], lo};
  endtask

  task automatic expect_pixel(string r, int hold);
    logic [14:0] p;
    read_pixel(hold, p);
    chk(r, p, pix(exp_idx));
    exp_idx++;
  endtask

  task automatic write_reg(input logic [1:0] a);
    @(negedge clk);
    cs_n = 1'b0; we = 1'b1; addr = a;
    @(negedge clk);
    cs_n = 1'b1; we = 1'b0; addr = 2'd0;
  endtask

  task automatic do_restart;
    write_reg(2'd2);
    @(negedge clk);
    chk("R7 addr cleared", faddr, '0);
    chk("R7 request dropped", req, 1'b0);
    chk("R1 empty read low", rdata, 8'h00);
    exp_idx = 0;
    idle(20);
  endtask

  task automatic finish_run;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] b0, b1;
    logic [14:0] p;
    void'($urandom(32'd1234));
    idle(3);
    chk("R1 no request in reset", req, 1'b0);
    chk("R1 addr zero in reset", faddr, '0);
    chk("R1 empty read low", rdata, 8'h00);
    addr = 2'd1;
    @(negedge clk);
    chk("R1 empty read high", rdata, 8'h00);
    addr = 2'd0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 request after reset", req, 1'b1);
    chk("R2 first address", faddr, '0);

    idle(40);
    chk("R4 pointer after fill", faddr, AW'(DEP));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2 no request when full", req, 1'b0);
    end

    // low byte reads do not pop
    read_byte(2'd0, 1, b0);
    read_byte(2'd0, 0, b1);
    chk("R6 low read no pop", b1, b0);
    addr = 2'd3;
    @(negedge clk);
    chk("R5 unused register", rdata, 8'h00);
    expect_pixel("R8 first pixel", 3);
    idle(12);

    // writes to data registers ignored
    write_reg(2'd0);
    write_reg(2'd1);
    idle(4);
    chk("R7 data writes ignored", faddr, AW'(DEP + 1));
    expect_pixel("R7 order kept after data writes", 0);

    // random readout past the address wrap
    for (int i = 0; i < 80; i++) begin
      idle(12 + int'($urandom % 9));
      expect_pixel("R4 R8 sequence", int'($urandom % 3));
    end

    // restarts with fetches in flight
    for (int k = 0; k < 6; k++) begin
      idle(int'($urandom % 8));
      do_restart();
      for (int j = 0; j < 3; j++) begin
        expect_pixel("R7 restart sequence", 0);
        idle(12);
      end
      if (k == 2) begin
        read_pixel(0, p);
        exp_idx++;
        do_restart();
        expect_pixel("R7 restart right after pop", 1);
        idle(12);
      end
    end
    finish_run();
  end
endmodule